// File: doc/BRIEF.md
# Watchdog Control Register Serial Slave

This block is a two-wire serial slave that sits beside a supervisor's watchdog and gives a host access to one 8-bit control byte. The byte holds the two watchdog period bits and two volatile write-enable latches. SCL and SDA arrive already synchronised to the block clock. The block answers by enabling a pull-down on SDA. It decodes the device byte, the address byte and a single data byte, and it commits each write only when a STOP follows.

A change to the period bits needs an unlock sequence of three writes. The first write arms the primary latch. The second write arms the secondary latch. The third write carries the new period bits. A write-protect input keeps the period bits frozen.

The same slave also recognises the two threshold-programming writes to the memory space. It reports each of them as a one-clock request pulse, and only while a high-voltage-present flag is asserted. Reads return the control byte once and then leave the bus.

Top module: `ctlreg_bus_slave`

## Requirements
- R1: After reset, sda_pd_o is 0, wd_o is 00, both request pulses are 0, and both latches read back as 0.
- R2: Device byte layout is bits 7:4 = preamble, bit 1 = address bit 8, bit 0 = direction (1 = read); bits 3:2 are ignored. Preamble 1011 is acknowledged in both directions. Preamble 1010 is acknowledged for writes only. Any other device byte is not acknowledged.
- R3: With preamble 1011, the address byte is acknowledged only when address bit 8 is 1 and the byte is FFh (register address 1FFh).
- R4: Within one transaction only the first data byte is acknowledged and stored. Later data bytes get no acknowledge and have no effect.
- R5: A committed register write of 02h sets the primary latch (read bit 1). A committed write of 06h while the primary latch is set sets the secondary latch (read bit 2).
- R6: When both latches are set, a committed register write loads wd_o from data bits 6:5 and clears the secondary latch. The primary latch stays set.
- R7: Register and request effects happen only on a STOP that follows an acknowledged data byte. A repeated START discards a pending byte.
- R8: While wp_i is high, wd_o does not change. The write still clears the secondary latch.
- R9: A read returns {0, WD1, WD0, 0, 0, secondary, primary, 0} MSB first. After the eighth bit the slave releases SDA and stays released without a STOP.
- R10: A committed write of 00h with preamble 1010 and address bit 8 = 0 gives a pulse when hv_i is 1. Address 01h gives a one-clock vset_o pulse and address 03h gives a one-clock vrst_o pulse. Other addresses or data values, or hv_i low, give no pulse.
- R11: The slave pulls SDA low only while SCL is low before the ninth pulse, and releases it after that pulse's falling edge.
- R12: A write of 06h without the primary latch, or a data write without both latches, changes neither the latches nor wd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (wired bus level) |
| wp_i | input | 1 | Write protect for the watchdog bits |
| hv_i | input | 1 | High programming voltage present |
| sda_pd_o | output | 1 | SDA pull-down enable |
| wd_o | output | 2 | Watchdog period bits WD1:WD0 |
| vset_o | output | 1 | Threshold-set request pulse |
| vrst_o | output | 1 | Threshold-reset request pulse |

## Verification
Every result is due one clock after the edge at which the block sees the bus event. SDA drive and release follow the clock after an SCL fall. wd_o and the latches follow the clock after the STOP's SDA rise, and a request pulse lasts exactly the next clock. The bench holds each bus phase for four clocks and samples only at the end of a phase, so every due output has settled. Pulses are counted on falling clock edges, so one count per transaction also confirms a width of one clock.

// File: rtl/ctlreg_bus_pkg.sv
package ctlreg_bus_pkg;
   typedef enum logic [2:0] {PH_IDLE, PH_SLV, PH_ADR, PH_DAT, PH_RD} phase_t;
   typedef enum logic {TG_ARR, TG_REG} target_t;

   function automatic logic [7:0] pack_reg(input logic [1:0] wd, input logic sec, input logic pri);
      return {1'b0, wd, 2'b00, sec, pri, 1'b0};
   endfunction
endpackage

// File: rtl/ctlreg_bus_cond.sv
module ctlreg_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ctlreg_bus_regs.sv
module ctlreg_bus_regs #(
   parameter int         BYTE_W   = 8,
   parameter logic [7:0] SET_ADDR = 8'h01,
   parameter logic [7:0] CLR_ADDR = 8'h03,
   parameter logic [7:0] KEY_PRI  = 8'h02,
   parameter logic [7:0] KEY_SEC  = 8'h06,
   parameter logic [1:0] WD_INIT  = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic              tgt_reg_i,
   input  logic [BYTE_W:0]   addr_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              wp_i,
   input  logic              hv_i,
   output logic [1:0]        wd_o,
   output logic              pri_o,
   output logic              sec_o,
   output logic              vset_o,
   output logic              vrst_o
);
   logic prog_ok;
   assign prog_ok = hv_i && (data_i == '0) && !addr_i[BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_o   <= WD_INIT;
         pri_o  <= 1'b0;
         sec_o  <= 1'b0;
         vset_o <= 1'b0;
         vrst_o <= 1'b0;
      end else begin
         vset_o <= 1'b0;
         vrst_o <= 1'b0;
         if (commit_i) begin
            if (tgt_reg_i) begin
               if (pri_o && sec_o) begin
                  if (!wp_i) wd_o <= data_i[6:5];
                  sec_o <= 1'b0;
               end else if (data_i == KEY_SEC && pri_o) begin
                  sec_o <= 1'b1;
               end else if (data_i == KEY_PRI) begin
                  pri_o <= 1'b1;
               end
            end else begin
               vset_o <= prog_ok && (addr_i[BYTE_W-1:0] == SET_ADDR);
               vrst_o <= prog_ok && (addr_i[BYTE_W-1:0] == CLR_ADDR);
            end
         end
      end
   end
endmodule

// File: rtl/ctlreg_bus_slave.sv
module ctlreg_bus_slave #(
   parameter int         BYTE_W   = 8,
   parameter int         PRE_W    = 4,
   parameter logic [3:0] REG_PRE  = 4'b1011,
   parameter logic [3:0] ARR_PRE  = 4'b1010,
   parameter logic [8:0] REG_ADDR = 9'h1FF,
   parameter logic [7:0] SET_ADDR = 8'h01,
   parameter logic [7:0] CLR_ADDR = 8'h03,
   parameter logic [7:0] KEY_PRI  = 8'h02,
   parameter logic [7:0] KEY_SEC  = 8'h06,
   parameter logic [1:0] WD_INIT  = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       wp_i,
   input  logic       hv_i,
   output logic       sda_pd_o,
   output logic [1:0] wd_o,
   output logic       vset_o,
   output logic       vrst_o
);
   import ctlreg_bus_pkg::*;

   localparam int             CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

   if (BYTE_W != 8) begin : g_bad_width
      $error("ctlreg_bus_slave: BYTE_W must be 8");
   end
   if (PRE_W != 4) begin : g_bad_pre
      $error("ctlreg_bus_slave: PRE_W must be 4");
   end
   if (REG_PRE == ARR_PRE) begin : g_bad_preamble
      $error("ctlreg_bus_slave: preambles must differ");
   end

   logic              rise, fall, start, stop;
   phase_t            ph;
   target_t           tgt;
   logic [CNT_W-1:0]  cnt;
   logic              ackph, ahi, got, ack_ok, commit;
   logic [BYTE_W-1:0] sh, adr, dat, tx, rd_byte;
   logic              pri, sec;

   ctlreg_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise_o(rise), .scl_fall_o(fall), .start_o(start), .stop_o(stop)
   );

   assign commit = stop && (ph == PH_DAT) && got;

   ctlreg_bus_regs #(
      .BYTE_W(BYTE_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR),
      .KEY_PRI(KEY_PRI), .KEY_SEC(KEY_SEC), .WD_INIT(WD_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .tgt_reg_i(tgt == TG_REG),
      .addr_i({ahi, adr}), .data_i(dat), .wp_i(wp_i), .hv_i(hv_i),
      .wd_o(wd_o), .pri_o(pri), .sec_o(sec), .vset_o(vset_o), .vrst_o(vrst_o)
   );

   assign rd_byte = pack_reg(wd_o, sec, pri);

   always_comb begin
      case (ph)
         PH_SLV:  ack_ok = (sh[BYTE_W-1 -: PRE_W] == REG_PRE) ||
                           ((sh[BYTE_W-1 -: PRE_W] == ARR_PRE) && !sh[0]);
         PH_ADR:  ack_ok = (tgt == TG_ARR) || ({ahi, sh} == REG_ADDR);
         PH_DAT:  ack_ok = !got;
         default: ack_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         tgt      <= TG_ARR;
         cnt      <= '0;
         ackph    <= 1'b0;
         ahi      <= 1'b0;
         got      <= 1'b0;
         sh       <= '0;
         adr      <= '0;
         dat      <= '0;
         tx       <= '0;
         sda_pd_o <= 1'b0;
      end else if (start) begin
         ph       <= PH_SLV;
         cnt      <= '0;
         ackph    <= 1'b0;
         got      <= 1'b0;
         sda_pd_o <= 1'b0;
      end else if (stop) begin
         ph       <= PH_IDLE;
         ackph    <= 1'b0;
         got      <= 1'b0;
         sda_pd_o <= 1'b0;
      end else begin
         case (ph)
            PH_IDLE: ;
            PH_RD: begin
               if (rise) begin
                  cnt <= cnt + 1'b1;
               end else if (fall) begin
                  if (cnt == LAST) begin
                     sda_pd_o <= 1'b0;
                     ph       <= PH_IDLE;
                  end else begin
                     sda_pd_o <= ~tx[BYTE_W-2];
                     tx       <= {tx[BYTE_W-2:0], 1'b0};
                  end
               end
            end
            default: begin
               if (rise && cnt != LAST) begin
                  sh  <= {sh[BYTE_W-2:0], sda_i};
                  cnt <= cnt + 1'b1;
               end else if (fall && cnt == LAST) begin
                  if (!ackph) begin
                     ackph    <= 1'b1;
                     sda_pd_o <= ack_ok;
                     if (!ack_ok && ph != PH_DAT) begin
                        ph  <= PH_IDLE;
                        cnt <= '0;
                     end
                  end else begin
                     ackph    <= 1'b0;
                     sda_pd_o <= 1'b0;
                     cnt      <= '0;
                     case (ph)
                        PH_SLV: begin
                           tgt <= (sh[BYTE_W-1 -: PRE_W] == REG_PRE) ? TG_REG : TG_ARR;
                           ahi <= sh[1];
                           if (sh[0]) begin
                              ph       <= PH_RD;
                              tx       <= rd_byte;
                              sda_pd_o <= ~rd_byte[BYTE_W-1];
                           end else begin
                              ph <= PH_ADR;
                           end
                        end
                        PH_ADR: begin
                           adr <= sh;
                           ph  <= PH_DAT;
                        end
                        default: begin
                           if (!got) begin
                              dat <= sh;
                              got <= 1'b1;
                           end
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/ctlreg_bus_slave_chk.sv
module ctlreg_bus_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_i,
   input logic       wp_i,
   input logic       hv_i,
   input logic       sda_pd_o,
   input logic [1:0] wd_o,
   input logic       vset_o,
   input logic       vrst_o
);
   // R10
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vset_o, vrst_o}));

   // R10
   set_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vset_o |=> !vset_o);

   // R10
   rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vrst_o |=> !vrst_o);

   // R10
   set_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vset_o || vrst_o) |-> $past(hv_i));

   // R7
   wd_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wd_o) |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2)));

   // R8
   wd_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wd_o) |-> !$past(wp_i));

   // R11
   pd_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pd_o) |-> !$past(scl_i));
endmodule

bind ctlreg_bus_slave ctlreg_bus_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
   .hv_i(hv_i), .sda_pd_o(sda_pd_o), .wd_o(wd_o), .vset_o(vset_o), .vrst_o(vrst_o)
);

// File: tb/ctlreg_bus_slave_bench.sv
`timescale 1ns/1ps
module ctlreg_bus_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0, hv = 1'b0;
   logic sda_bus, sda_pd, vset, vrst;
   logic [1:0] wd;
   int n_chk = 0, n_bad = 0, n_set = 0, n_rst = 0;

   always #4 clk = ~clk;
   assign sda_bus = sda_m & ~sda_pd;

   ctlreg_bus_slave u_ctlreg_bus_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wp_i(wp), .hv_i(hv),
      .sda_pd_o(sda_pd), .wd_o(wd), .vset_o(vset), .vrst_o(vrst)
   );

   always @(negedge clk) begin
      if (vset) n_set++;
      if (vrst) n_rst++;
   end

   // slave byte, address, data, wp, hv, expected wd, expected set/reset pulse
   localparam logic [29:0] VEC [0:13] = '{
      {8'hB2, 8'hFF, 8'h02, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h06, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h60, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h20, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h06, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h20, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h06, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0},
      {8'hB2, 8'hFF, 8'h40, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0},
      {8'hA0, 8'h01, 8'h00, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0},
      {8'hA0, 8'h03, 8'h00, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1},
      {8'hA0, 8'h01, 8'h00, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0},
      {8'hA0, 8'h01, 8'h05, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
      {8'hA0, 8'h02, 8'h00, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0},
      {8'hA2, 8'h01, 8'h00, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(); scl = 1'b1; tick(); sda_m = 1'b0; tick(); scl = 1'b0; tick();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(); scl = 1'b1; tick(); sda_m = 1'b1; tick(); tick();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack, output logic rel);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(); scl = 1'b1; tick(); scl = 1'b0; tick();
      end
      sda_m = 1'b1; tick(); scl = 1'b1; tick();
      ack = sda_pd;
      scl = 1'b0; tick();
      rel = !sda_pd;
   endtask

   task automatic rbyte(output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         scl = 1'b1; tick(); v[i] = sda_bus; scl = 1'b0; tick();
      end
      scl = 1'b1; tick(); scl = 1'b0; tick();
   endtask

   task automatic wr3(input logic [7:0] s, input logic [7:0] a, input logic [7:0] d);
      logic k, r;
      bus_start(); wbyte(s, k, r); wbyte(a, k, r); wbyte(d, k, r); bus_stop();
   endtask

   task automatic rd_reg(input string tag, input logic [7:0] exp);
      logic k, r;
      logic [7:0] v;
      bus_start(); wbyte(8'hB3, k, r);
      check({tag, " read ack"}, 32'(k), 32'd1);
      rbyte(v);
      check(tag, 32'(v), 32'(exp));
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic k1, k2, k3, r1, r2, r3;
      logic [7:0] v;
      int s0, t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 sda_pd reset", 32'(sda_pd), 0);
      check("R1 wd reset", 32'(wd), 0);
      check("R1 pulses reset", 32'(vset | vrst), 0);
      rd_reg("R1 R9 latches after reset", 8'h00);

      // table walk
      for (int j = 0; j < 14; j++) begin
         logic [29:0] e;
         e = VEC[j];
         wp = e[5]; hv = e[4];
         s0 = n_set; t0 = n_rst;
         bus_start();
         wbyte(e[29:22], k1, r1);
         wbyte(e[21:14], k2, r2);
         wbyte(e[13:6], k3, r3);
         check("R2 slave ack", 32'(k1), 1);
         check("R3 addr ack", 32'(k2), 1);
         check("R4 data ack", 32'(k3), 1);
         check("R11 release after ack", 32'(r1 & r2 & r3), 1);
         bus_stop();
         check("R5 R6 R8 R12 wd after stop", 32'(wd), 32'(e[3:2]));
         check("R10 set pulses", 32'(n_set - s0), 32'(e[1]));
         check("R10 reset pulses", 32'(n_rst - t0), 32'(e[0]));
         wp = 1'b0; hv = 1'b0;
      end

      // R6 primary latch stays, secondary cleared; R9 read then bus left released
      bus_start(); wbyte(8'hB3, k1, r1);
      check("R2 register read ack", 32'(k1), 1);
      rbyte(v);
      check("R6 R9 read byte", 32'(v), 32'h42);
      k2 = 1'b0;
      for (int i = 0; i < 3; i++) begin
         scl = 1'b1; tick(); k2 = k2 | sda_pd; scl = 1'b0; tick(); k2 = k2 | sda_pd;
      end
      check("R9 idle after read", 32'(k2), 0);
      bus_stop();

      // R5 secondary latch
      wr3(8'hB2, 8'hFF, 8'h06);
      rd_reg("R5 both latches", 8'h46);

      // R7 nothing before stop; R4 extra byte refused
      bus_start(); wbyte(8'hB2, k1, r1); wbyte(8'hFF, k1, r1); wbyte(8'h00, k1, r1);
      check("R7 wd held before stop", 32'(wd), 32'h2);
      wbyte(8'h60, k2, r2);
      check("R4 second data nack", 32'(k2), 0);
      bus_stop();
      check("R4 R7 wd from first byte", 32'(wd), 0);
      rd_reg("R6 secondary cleared", 8'h02);

      // R7 repeated start discards
      bus_start(); wbyte(8'hB2, k1, r1); wbyte(8'hFF, k1, r1); wbyte(8'h06, k1, r1);
      bus_start(); bus_stop();
      rd_reg("R7 discarded by restart", 8'h02);

      // R2 refused device bytes
      bus_start(); wbyte(8'h90, k1, r1);
      check("R2 foreign preamble nack", 32'(k1), 0);
      bus_stop();
      bus_start(); wbyte(8'hA1, k1, r1);
      check("R2 array read nack", 32'(k1), 0);
      bus_stop();

      // R3 wrong register address
      bus_start(); wbyte(8'hB2, k1, r1); wbyte(8'hFE, k2, r2);
      check("R3 addr FEh nack", 32'(k2), 0);
      bus_stop();
      bus_start(); wbyte(8'hB0, k1, r1); wbyte(8'hFF, k2, r2);
      check("R3 addr 0FFh nack", 32'(k2), 0);
      bus_stop();

      // R1 reset clears latches; R12 out-of-order writes ignored
      rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
      check("R1 wd after reset", 32'(wd), 0);
      rd_reg("R1 latches after reset", 8'h00);
      wr3(8'hB2, 8'hFF, 8'h06);
      rd_reg("R12 secondary without primary", 8'h00);
      wr3(8'hB2, 8'hFF, 8'h60);
      check("R12 wd without unlock", 32'(wd), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule